// File: doc/BRIEF.md
# Flash Write-Status Flag Generator

This block produces the byte that a NOR-style flash part places on its data pins when the host reads during an internal program or erase operation. On each read the byte is built from the current operating state, the data last written, and two toggle bits that change from one read to the next. The host polls these flags to find out whether the operation is still running, whether it has run too long, and which sector an erase was suspended in.

The flash array, command decoding and the real algorithm timing are outside the block. The operating state, a time-limit flag, the last written byte, the array data, a flag marking the read address as inside the erase-suspended sector, and a start pulse all come in as plain inputs. The output byte is registered on the rising edge of the read strobe and holds its value until the next read.

Top module: `flash_status_gen`

## Requirements
- R1: With mode_i = 1 (program), a read returns bit 7 as the inverse of bit 7 of last_data_i, bit 2 = 1 and bit 3 = 0.
- R2: With mode_i = 2 (erase), a read returns bit 7 = 0 and bit 3 = 1.
- R3: In modes 1, 2 and 4, bit 6 reads 0 on the first read after a start pulse and inverts on each later read.
- R4: With mode_i = 2, bit 2 reads 0 on the first read after a start pulse and inverts on each later read.
- R5: In modes 1, 2 and 4, bit 5 equals timeout_i; bits 7 and 6 keep their in-progress behaviour while timeout_i is 1.
- R6: With mode_i = 3 (suspend read) and in_susp_sector_i = 1, a read returns bit 7 = 1, bit 6 = 1, bit 5 = 0, bit 3 = 0, and bit 2 toggling as in R4.
- R7: With mode_i = 3 and in_susp_sector_i = 0, a read returns array_data_i unchanged and no toggle bit advances.
- R8: With mode_i = 4 (suspend program), bit 7 is the inverse of last_data_i bit 7, bit 3 = 0, and bit 2 is 1 when in_susp_sector_i = 0 and toggles as in R4 when it is 1.
- R9: In every status read (modes 1, 2, 4, and mode 3 with in_susp_sector_i = 1), bits 4, 1 and 0 are 0.
- R10: With mode_i = 0 (idle) or any code 5 to 7, a read returns array_data_i, so a finished operation reads its true data.
- R11: A start_i pulse sets both toggle bits back to 0 and takes priority over a read in the same cycle.
- R12: status_o is 0 after reset, changes only in the clock after a rising edge of rd_i, and holds while rd_i stays high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Operating state: 0 idle, 1 program, 2 erase, 3 suspend read, 4 suspend program |
| timeout_i | input | 1 | Internal algorithm exceeded its time limit |
| start_i | input | 1 | New operation begins; clears the toggle bits |
| last_data_i | input | 8 | Data byte last written by the host |
| array_data_i | input | 8 | Array contents at the read address |
| in_susp_sector_i | input | 1 | Read address lies in the erase-suspended sector |
| rd_i | input | 1 | Read strobe; a read occurs on its rising edge |
| status_o | output | 8 | Status or data byte of the last read |

## Verification
A toggle bit stuck or advanced on the wrong read shows up as two equal bit 6 or bit 2 values on back-to-back reads, visible at the second read after the fault. A wrong mode decode flips bit 7, bit 3 or the reserved bits in the very read that follows, one clock after the strobe rises. A broken edge detector shows as status_o changing while rd_i is held high, seen within one clock.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MD_IDLE    = 3'd0,
        MD_PROG    = 3'd1,
        MD_ERASE   = 3'd2,
        MD_SUSP_RD = 3'd3,
        MD_SUSP_PG = 3'd4
    } mode_e;

    typedef struct packed {
        logic poll;   // bit 7: data polling
        logic tgl;    // bit 6: per-read toggle
        logic tlim;   // bit 5: time limit exceeded
        logic rsv4;   // bit 4: no status meaning
        logic ers;    // bit 3: erase flag
        logic tgl2;   // bit 2: sector toggle
        logic rsv1;   // bit 1: reserved
        logic rsv0;   // bit 0: reserved
    } status_t;

    function automatic mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return MD_PROG;
            3'd2:    return MD_ERASE;
            3'd3:    return MD_SUSP_RD;
            3'd4:    return MD_SUSP_PG;
            default: return MD_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/fsg_read_edge.sv
module fsg_read_edge (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    output logic rise_o
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= rd_i;
    end

    assign rise_o = rd_i & ~rd_q;

    AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R12
endmodule

// File: rtl/fsg_toggle_bits.sv
module fsg_toggle_bits (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic adv6_i,
    input  logic adv2_i,
    output logic t6_o,
    output logic t2_o
);
    logic t6_q, t2_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            t6_q <= 1'b0;
            t2_q <= 1'b0;
        end else begin
            if (adv6_i) t6_q <= ~t6_q;
            if (adv2_i) t2_q <= ~t2_q;
        end
    end

    assign t6_o = t6_q;
    assign t2_o = t2_q;

    AST_TOGGLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!t6_o && !t2_o)); // R11
    AST_T6_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!adv6_i && !clear_i) |=> $stable(t6_o)); // R7
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
    import flash_status_pkg::*;
(
    input  mode_e              md_i,
    input  logic               timeout_i,
    input  logic [BYTE_W-1:0]  last_data_i,
    input  logic [BYTE_W-1:0]  array_data_i,
    input  logic               in_susp_i,
    input  logic               t6_i,
    input  logic               t2_i,
    output logic [BYTE_W-1:0]  byte_o,
    output logic               is_status_o,
    output logic               adv6_o,
    output logic               adv2_o
);
    status_t st;
    logic    use_arr;

    always_comb begin
        st      = '0;
        use_arr = 1'b0;
        adv6_o  = 1'b0;
        adv2_o  = 1'b0;
        case (md_i)
            MD_PROG: begin
                st.poll = ~last_data_i[BYTE_W-1];
                st.tgl  = t6_i;
                st.tlim = timeout_i;
                st.tgl2 = 1'b1;
                adv6_o  = 1'b1;
            end
            MD_ERASE: begin
                st.poll = 1'b0;
                st.tgl  = t6_i;
                st.tlim = timeout_i;
                st.ers  = 1'b1;
                st.tgl2 = t2_i;
                adv6_o  = 1'b1;
                adv2_o  = 1'b1;
            end
            MD_SUSP_RD: begin
                if (in_susp_i) begin
                    st.poll = 1'b1;
                    st.tgl  = 1'b1;
                    st.tgl2 = t2_i;
                    adv2_o  = 1'b1;
                end else begin
                    use_arr = 1'b1;
                end
            end
            MD_SUSP_PG: begin
                st.poll = ~last_data_i[BYTE_W-1];
                st.tgl  = t6_i;
                st.tlim = timeout_i;
                st.tgl2 = in_susp_i ? t2_i : 1'b1;
                adv6_o  = 1'b1;
                adv2_o  = in_susp_i;
            end
            default: use_arr = 1'b1;
        endcase
    end

    assign byte_o      = use_arr ? array_data_i : st;
    assign is_status_o = ~use_arr;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic              timeout_i,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] last_data_i,
    input  logic [BYTE_W-1:0] array_data_i,
    input  logic              in_susp_sector_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] status_o
);
    mode_e             md;
    logic              rd_rise;
    logic              t6, t2;
    logic              adv6, adv2, is_status;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] status_q;

    assign md = decode_mode(mode_i);

    fsg_read_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .rd_i   (rd_i),
        .rise_o (rd_rise)
    );

    fsg_toggle_bits u_tgl (
        .clk     (clk),
        .rst     (rst),
        .clear_i (start_i),
        .adv6_i  (rd_rise & adv6),
        .adv2_i  (rd_rise & adv2),
        .t6_o    (t6),
        .t2_o    (t2)
    );

    fsg_status_mux u_mux (
        .md_i         (md),
        .timeout_i    (timeout_i),
        .last_data_i  (last_data_i),
        .array_data_i (array_data_i),
        .in_susp_i    (in_susp_sector_i),
        .t6_i         (t6),
        .t2_i         (t2),
        .byte_o       (next_byte),
        .is_status_o  (is_status),
        .adv6_o       (adv6),
        .adv2_o       (adv2)
    );

    always_ff @(posedge clk) begin
        if (rst)          status_q <= '0;
        else if (rd_rise) status_q <= next_byte;
    end

    assign status_o = status_q;

    AST_PROG_POLL_INV: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && md == MD_PROG) |=> (status_o[7] != $past(last_data_i[7]))); // R1
    AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && md == MD_ERASE) |=> (!status_o[7] && status_o[3])); // R2
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && is_status) |=> (status_o[1:0] == 2'b00 && !status_o[4])); // R9
    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_rise |=> $stable(status_o)); // R12
    AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && md == MD_IDLE) |=> (status_o == $past(array_data_i))); // R10
endmodule

// File: tb/test_flash_status_gen.sv
module test_flash_status_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] mode_i;
    logic       timeout_i;
    logic       start_i;
    logic [7:0] last_data_i;
    logic [7:0] array_data_i;
    logic       in_susp_sector_i;
    logic       rd_i;
    logic [7:0] status_o;

    int checks = 0;
    int failures = 0;
    logic e6, e2;

    always #2 clk = ~clk; // 250 MHz

    flash_status_gen i_flash_status_gen (
        .clk              (clk),
        .rst              (rst),
        .mode_i           (mode_i),
        .timeout_i        (timeout_i),
        .start_i          (start_i),
        .last_data_i      (last_data_i),
        .array_data_i     (array_data_i),
        .in_susp_sector_i (in_susp_sector_i),
        .rd_i             (rd_i),
        .status_o         (status_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        e6 = 1'b0;
        e2 = 1'b0;
    endtask

    task automatic do_read(output logic [7:0] val);
        rd_i = 1'b1;
        @(negedge clk);
        val = status_o;
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 reset", status_o, 8'h00);
    endtask

    task automatic t_program();
        logic [7:0] v;
        mode_i = 3'd1; timeout_i = 1'b0; last_data_i = 8'h3C; array_data_i = 8'hFF;
        do_start();
        for (int i = 0; i < 3; i++) begin
            do_read(v);
            chk("R1 R3 program", v, {1'b1, e6, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00});
            e6 = ~e6;
        end
        last_data_i = 8'h80;
        do_read(v);
        chk("R1 program inverted bit7", v, {1'b0, e6, 6'b000100});
        e6 = ~e6;
    endtask

    task automatic t_erase();
        logic [7:0] v;
        mode_i = 3'd2; timeout_i = 1'b0;
        do_start();
        for (int i = 0; i < 4; i++) begin
            do_read(v);
            chk("R2 R3 R4 erase", v, {1'b0, e6, 1'b0, 1'b0, 1'b1, e2, 2'b00});
            e6 = ~e6; e2 = ~e2;
        end
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        mode_i = 3'd1; timeout_i = 1'b1; last_data_i = 8'h00;
        do_start();
        for (int i = 0; i < 2; i++) begin
            do_read(v);
            chk("R5 program timeout", v, {1'b1, e6, 1'b1, 5'b00100});
            e6 = ~e6;
        end
        mode_i = 3'd2;
        do_read(v);
        chk("R5 erase timeout", v, {1'b0, e6, 1'b1, 1'b0, 1'b1, e2, 2'b00});
        e6 = ~e6; e2 = ~e2;
        timeout_i = 1'b0;
    endtask

    task automatic t_susp_read();
        logic [7:0] v;
        mode_i = 3'd3; timeout_i = 1'b1; array_data_i = 8'hA5;
        do_start();
        in_susp_sector_i = 1'b1;
        do_read(v);
        chk("R6 susp sector", v, {2'b11, 3'b000, e2, 2'b00});
        e2 = ~e2;
        in_susp_sector_i = 1'b0;
        do_read(v);
        chk("R7 other sector data", v, 8'hA5);
        in_susp_sector_i = 1'b1;
        do_read(v);
        chk("R6 R7 susp sector toggle kept", v, {2'b11, 3'b000, e2, 2'b00});
        e2 = ~e2;
        timeout_i = 1'b0;
    endtask

    task automatic t_susp_prog();
        logic [7:0] v;
        mode_i = 3'd4; last_data_i = 8'h7F;
        do_start();
        in_susp_sector_i = 1'b0;
        do_read(v);
        chk("R8 susp prog byte", v, {1'b1, e6, 6'b000100});
        e6 = ~e6;
        in_susp_sector_i = 1'b1;
        do_read(v);
        chk("R8 susp prog sector", v, {1'b1, e6, 3'b000, e2, 2'b00});
        e6 = ~e6; e2 = ~e2;
        do_read(v);
        chk("R8 R9 susp prog sector again", v, {1'b1, e6, 3'b000, e2, 2'b00});
        e6 = ~e6; e2 = ~e2;
        in_susp_sector_i = 1'b0;
    endtask

    task automatic t_idle();
        logic [7:0] v;
        mode_i = 3'd0; array_data_i = 8'h5A;
        do_read(v);
        chk("R10 idle data", v, 8'h5A);
        mode_i = 3'd6; array_data_i = 8'hC3;
        do_read(v);
        chk("R10 unused code", v, 8'hC3);
    endtask

    task automatic t_start_priority();
        logic [7:0] v;
        mode_i = 3'd2;
        do_start();
        do_read(v);
        e6 = 1'b1; e2 = 1'b1;
        // read and start together: toggles must end cleared
        rd_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        e6 = 1'b0; e2 = 1'b0;
        do_read(v);
        chk("R11 start priority", v, {1'b0, e6, 3'b001, e2, 2'b00});
    endtask

    task automatic t_hold();
        logic [7:0] v;
        mode_i = 3'd0; array_data_i = 8'h11;
        rd_i = 1'b1;
        @(negedge clk);
        array_data_i = 8'h22;
        @(negedge clk);
        @(negedge clk);
        chk("R12 hold while high", status_o, 8'h11);
        rd_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 hold while low", status_o, 8'h11);
        do_read(v);
        chk("R12 next rise", v, 8'h22);
    endtask

    initial begin
        rst = 1'b1; mode_i = 3'd0; timeout_i = 1'b0; start_i = 1'b0;
        last_data_i = 8'h00; array_data_i = 8'h00; in_susp_sector_i = 1'b0; rd_i = 1'b0;
        e6 = 1'b0; e2 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_timeout();
        t_susp_read();
        t_susp_prog();
        t_idle();
        t_start_priority();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule